// File: doc/BRIEF.md
# Byte-to-Word DMA FIFO Bridge

This block sits between a byte-wide peripheral port and a 16-bit host DMA engine and buffers disk data in a 64-byte FIFO. A loaded 8-bit command picks the port's role. It can open the FIFO for data transfer, present a status byte, or release the interrupt request line. The peripheral moves one byte per chip-select strobe. The direction is set by a read/write control: when that control is low, bytes go into the FIFO on the strobe's rising edge. When it is high, bytes come out of the FIFO on the strobe's falling edge.

On the host side the block raises a DMA request around the half-full mark. Each grant moves one 16-bit word, and the first byte of every pair sits in the upper half of the word. A block-end pulse flushes the bytes that remain toward the host, and an odd final byte is padded with zeros. If a strobe finds the FIFO full on a write, or empty on a read, the grant has come too late. A sticky error flag then freezes all transfers until a synchronous clear. The interrupt line is modelled as an open-drain pull-down enable: the host sets it and a command releases it.

Top module: `dma_fifo_bridge`

## Requirements
- R1: After reset the FIFO is empty, dmaReq and irqPullLow are low, and the mode is idle. A status read with rdWrN low then returns 0xE0.
- R2: On cmdLoad, code 0xF7 selects FIFO mode, 0xEF selects status mode, 0x9F and every other code select idle mode. In idle mode perDataOut is 0 and strobes have no effect on the FIFO.
- R3: In FIFO mode with rdWrN low, a low-to-high change of strobeN, seen between two clock samples, appends perDataIn to the FIFO if the FIFO held fewer than 64 bytes.
- R4: hostWordOut shows the FIFO head with the older byte in bits 15:8 and the next byte in bits 7:0. It reads 0 when the FIFO is empty.
- R5: With rdWrN low in FIFO mode and no error, dmaReq is high while the FIFO holds at least 32 bytes, or while a block end is pending and the FIFO is not empty. A cycle with dmaGrant and dmaReq both high removes one word.
- R6: When such a grant finds only one byte in the FIFO, it removes that byte and hostWordOut shows it as {byte, 8'h00}. A blockEnd pulse keeps the flush pending until the FIFO is empty.
- R7: In FIFO mode with rdWrN high, a high-to-low change of strobeN removes the head byte when the FIFO is not empty. perDataOut holds that byte from the next clock onward.
- R8: With rdWrN high in FIFO mode and no error, dmaReq is high while the FIFO holds at most 32 bytes. A grant appends hostWordIn[15:8] and then hostWordIn[7:0].
- R9: A write strobe that finds 64 bytes, or a read strobe that finds 0 bytes, sets a sticky error. While the error is set, strobes are ignored, dmaReq stays low and status bit 5 reads 0.
- R10: A clrFifo cycle empties the FIFO, cancels a pending flush and clears the error, taking priority over any strobe or grant in that cycle.
- R11: In status mode perDataOut is {~dmaReq, ready, ~error, 5'b00000}. Ready is "not empty" when rdWrN is high and "not full" when rdWrN is low. Strobes in status mode change nothing.
- R12: An irqAssert cycle sets irqPullLow. Loading command 0x9F clears it and wins over irqAssert in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrFifo | input | 1 | Synchronous FIFO and error clear |
| cmdLoad | input | 1 | Load cmdCode as the current command |
| cmdCode | input | 8 | Command byte |
| rdWrN | input | 1 | 1: FIFO to peripheral, 0: peripheral to FIFO |
| strobeN | input | 1 | Active-low chip-select strobe, sampled on clk |
| perDataIn | input | 8 | Byte written by the peripheral |
| perDataOut | output | 8 | Byte read by the peripheral or status byte |
| blockEnd | input | 1 | Pulse marking the end of a block; flushes remaining bytes |
| dmaReq | output | 1 | Host DMA request |
| dmaGrant | input | 1 | Host bus grant; one word per granted cycle |
| hostWordIn | input | 16 | Word from host memory |
| hostWordOut | output | 16 | Word toward host memory |
| irqAssert | input | 1 | Host sets the interrupt pull-down |
| irqPullLow | output | 1 | Interrupt line pull-down enable (0 means released) |

## Verification
A behavioural queue model is stepped with the design on every clock and compared on every output. The main function is driven in several ways, and each pattern separates a different fault. Even-length write blocks expose the byte order and the 32-byte threshold. An odd five-byte block with a flush shows whether the final byte is padded or lost. Host-word fills followed by byte reads show the fill order and the 32-byte stop on the read side. A write run to 65 bytes and a read run past empty with no grants show whether the error is sticky, whether it blocks traffic, and whether the clear really resets the FIFO. Strobes in idle and status modes confirm that those modes leave the FIFO untouched.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_FIFO   = 2'd1,
    MODE_STATUS = 2'd2
  } mode_t;

  localparam logic [7:0] CMD_FIFO   = 8'hF7;
  localparam logic [7:0] CMD_STATUS = 8'hEF;
  localparam logic [7:0] CMD_IRQREL = 8'h9F;

  // strobes from control to datapath, at most one of each per cycle
  typedef struct packed {
    logic clear;   // empty the FIFO
    logic wrByte;  // append one peripheral byte
    logic wrWord;  // append host word, high byte first
    logic rdByte;  // pop one byte to the peripheral
    logic rdWord;  // pop up to two bytes toward the host
  } ctl_t;

endpackage

// File: rtl/dmab_datapath.sv
module dmab_datapath
  import dmab_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctl_t                       ctl,
  input  logic [7:0]                 byteIn,
  input  logic [15:0]                wordIn,
  output logic [$clog2(DEPTH):0]     count,
  output logic [15:0]                wordOut,
  output logic [7:0]                 byteOut
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic [CW-1:0] pushN, popN;
  logic          pairAvail;

  assign wrNext    = wrPtr + AW'(1);
  assign rdNext    = rdPtr + AW'(1);
  assign pairAvail = count >= CW'(2);

  always_comb begin
    pushN = '0;
    popN  = '0;
    if (ctl.wrByte) pushN = CW'(1);
    if (ctl.wrWord) pushN = CW'(2);
    if (ctl.rdByte) popN  = CW'(1);
    if (ctl.rdWord) popN  = pairAvail ? CW'(2) : CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!ctl.clear) begin
      if (ctl.wrByte) mem[wrPtr] <= byteIn;
      if (ctl.wrWord) begin
        mem[wrPtr]  <= wordIn[15:8];
        mem[wrNext] <= wordIn[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      byteOut <= '0;
    end else if (ctl.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushN);
      rdPtr <= rdPtr + AW'(popN);
      count <= count + pushN - popN;
      if (ctl.rdByte) byteOut <= mem[rdPtr];
    end
  end

  assign wordOut = (count == '0) ? 16'h0000
                 : {mem[rdPtr], pairAvail ? mem[rdNext] : 8'h00};

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));                                         // R3
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdByte |-> count != '0);                                  // R7
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrByte |-> count != CW'(DEPTH));                          // R9
  AST_WORD_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrWord |-> count <= CW'(DEPTH - 2));                      // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> count == '0);                                   // R10

endmodule

// File: rtl/dmab_control.sv
module dmab_control
  import dmab_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clrFifo,
  input  logic                   cmdLoad,
  input  logic [7:0]             cmdCode,
  input  logic                   rdWrN,
  input  logic                   strobeN,
  input  logic                   blockEnd,
  input  logic                   dmaGrant,
  input  logic                   irqAssert,
  input  logic [$clog2(DEPTH):0] count,
  input  logic [7:0]             byteOut,
  output ctl_t                   ctl,
  output logic [7:0]             perDataOut,
  output logic                   dmaReq,
  output logic                   irqPullLow
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  mode_t mode;
  logic  strobePrev, err, drain, errSet;
  logic  fifoOn, fall, rise, grantAct, ready;
  logic  [7:0] statusByte;

  assign fifoOn   = (mode == MODE_FIFO);
  assign fall     = strobePrev & ~strobeN;
  assign rise     = ~strobePrev & strobeN;
  assign dmaReq   = fifoOn && !err &&
                    (rdWrN ? (count <= CW'(HALF))
                           : (count >= CW'(HALF) || (drain && count != '0)));
  assign grantAct = dmaGrant && dmaReq;

  always_comb begin
    ctl       = '0;
    errSet    = 1'b0;
    ctl.clear = clrFifo;
    if (!clrFifo) begin
      if (fifoOn && !err) begin
        if (!rdWrN && rise) begin
          if (count == CW'(DEPTH)) errSet = 1'b1;
          else                     ctl.wrByte = 1'b1;
        end
        if (rdWrN && fall) begin
          if (count == '0) errSet = 1'b1;
          else             ctl.rdByte = 1'b1;
        end
      end
      if (grantAct) begin
        if (rdWrN) ctl.wrWord = 1'b1;
        else       ctl.rdWord = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode       <= MODE_IDLE;
      strobePrev <= 1'b1;
      err        <= 1'b0;
      drain      <= 1'b0;
      irqPullLow <= 1'b0;
    end else begin
      strobePrev <= strobeN;
      if (cmdLoad) begin
        case (cmdCode)
          CMD_FIFO:   mode <= MODE_FIFO;
          CMD_STATUS: mode <= MODE_STATUS;
          default:    mode <= MODE_IDLE;
        endcase
      end
      if (clrFifo) begin
        err   <= 1'b0;
        drain <= 1'b0;
      end else begin
        if (errSet)             err   <= 1'b1;
        if (blockEnd)           drain <= 1'b1;
        else if (count == '0)   drain <= 1'b0;
      end
      if (cmdLoad && cmdCode == CMD_IRQREL) irqPullLow <= 1'b0;
      else if (irqAssert)                   irqPullLow <= 1'b1;
    end
  end

  assign ready      = rdWrN ? (count != '0) : (count != CW'(DEPTH));
  assign statusByte = {~dmaReq, ready, ~err, 5'b00000};

  always_comb begin
    case (mode)
      MODE_FIFO:   perDataOut = byteOut;
      MODE_STATUS: perDataOut = statusByte;
      default:     perDataOut = 8'h00;
    endcase
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    err && !clrFifo |=> err);                                     // R9
  AST_CLEAR_ERR: assert property (@(posedge clk) disable iff (!rstN)
    clrFifo |=> !err);                                            // R10
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad && cmdCode == CMD_IRQREL |=> !irqPullLow);            // R12
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    irqAssert && !cmdLoad |=> irqPullLow);                        // R12

endmodule

// File: rtl/dma_fifo_bridge.sv
module dma_fifo_bridge
  import dmab_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clrFifo,
  input  logic        cmdLoad,
  input  logic [7:0]  cmdCode,
  input  logic        rdWrN,
  input  logic        strobeN,
  input  logic [7:0]  perDataIn,
  output logic [7:0]  perDataOut,
  input  logic        blockEnd,
  output logic        dmaReq,
  input  logic        dmaGrant,
  input  logic [15:0] hostWordIn,
  output logic [15:0] hostWordOut,
  input  logic        irqAssert,
  output logic        irqPullLow
);
  localparam int CW = $clog2(DEPTH) + 1;

  ctl_t          ctl;
  logic [CW-1:0] count;
  logic [7:0]    byteOut;

  dmab_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .clrFifo(clrFifo), .cmdLoad(cmdLoad),
    .cmdCode(cmdCode), .rdWrN(rdWrN), .strobeN(strobeN),
    .blockEnd(blockEnd), .dmaGrant(dmaGrant), .irqAssert(irqAssert),
    .count(count), .byteOut(byteOut), .ctl(ctl),
    .perDataOut(perDataOut), .dmaReq(dmaReq), .irqPullLow(irqPullLow)
  );

  dmab_datapath #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteIn(perDataIn),
    .wordIn(hostWordIn), .count(count), .wordOut(hostWordOut),
    .byteOut(byteOut)
  );

endmodule

// File: tb/tb_dma_fifo_bridge.sv
module tb_dma_fifo_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clrFifo = 1'b0, cmdLoad = 1'b0, rdWrN = 1'b0, strobeN = 1'b1;
  logic        blockEnd = 1'b0, dmaGrant = 1'b0, irqAssert = 1'b0;
  logic [7:0]  cmdCode = 8'h00, perDataIn = 8'h00;
  logic [15:0] hostWordIn = 16'h0000;
  logic [7:0]  perDataOut;
  logic [15:0] hostWordOut;
  logic        dmaReq, irqPullLow;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_fifo_bridge dut (
    .clk(clk), .rstN(rstN), .clrFifo(clrFifo), .cmdLoad(cmdLoad),
    .cmdCode(cmdCode), .rdWrN(rdWrN), .strobeN(strobeN),
    .perDataIn(perDataIn), .perDataOut(perDataOut), .blockEnd(blockEnd),
    .dmaReq(dmaReq), .dmaGrant(dmaGrant), .hostWordIn(hostWordIn),
    .hostWordOut(hostWordOut), .irqAssert(irqAssert), .irqPullLow(irqPullLow)
  );

  // ---------------- behavioural reference ----------------
  byte unsigned q[$];
  int  mMode = 0;          // 0 idle, 1 fifo, 2 status
  bit  mErr = 0, mDrain = 0, mPrev = 1, mIrq = 0;
  byte unsigned mOut = 0;

  function automatic bit expReq();
    int n = q.size();
    if (mMode != 1 || mErr) return 0;
    if (rdWrN) return n <= 32;
    return n >= 32 || (mDrain && n != 0);
  endfunction

  function automatic logic [7:0] expData();
    int n = q.size();
    bit rdy = rdWrN ? (n != 0) : (n != 64);
    if (mMode == 1) return mOut;
    if (mMode == 2) return {~expReq(), rdy, ~mErr, 5'b0};
    return 8'h00;
  endfunction

  function automatic logic [15:0] expWord();
    if (q.size() == 0) return 16'h0000;
    if (q.size() == 1) return {q[0], 8'h00};
    return {q[0], q[1]};
  endfunction

  always @(posedge clk or negedge rstN) begin : model
    int n;
    bit req, fall, rise;
    if (!rstN) begin
      q.delete(); mMode = 0; mErr = 0; mDrain = 0; mPrev = 1; mIrq = 0; mOut = 0;
    end else begin
      n = q.size();
      req = expReq();
      fall = mPrev && !strobeN;
      rise = !mPrev && strobeN;
      if (clrFifo) begin
        q.delete(); mErr = 0; mDrain = 0;
      end else begin
        if (dmaGrant && req && !rdWrN) begin
          void'(q.pop_front());
          if (n >= 2) void'(q.pop_front());
        end
        if (mMode == 1 && !mErr) begin
          if (rdWrN && fall) begin
            if (n == 0) mErr = 1; else mOut = q.pop_front();
          end
          if (!rdWrN && rise) begin
            if (n == 64) mErr = 1; else q.push_back(perDataIn);
          end
        end
        if (dmaGrant && req && rdWrN) begin
          q.push_back(hostWordIn[15:8]);
          q.push_back(hostWordIn[7:0]);
        end
        if (blockEnd) mDrain = 1;
        else if (n == 0) mDrain = 0;
      end
      mPrev = strobeN;
      if (cmdLoad) mMode = (cmdCode == 8'hF7) ? 1 : (cmdCode == 8'hEF) ? 2 : 0;
      if (cmdLoad && cmdCode == 8'h9F) mIrq = 0;
      else if (irqAssert) mIrq = 1;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(rdWrN ? "R8 dmaReq" : "R5 dmaReq", 16'(dmaReq), 16'(expReq()));
      check("R11 perDataOut", 16'(perDataOut), 16'(expData()));
      check("R4 hostWordOut", hostWordOut, expWord());
      check("R12 irqPullLow", 16'(irqPullLow), 16'(mIrq));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic command(logic [7:0] c);
    cmdCode = c; cmdLoad = 1'b1; tick(); cmdLoad = 1'b0;
  endtask

  task automatic strobe(logic [7:0] d);
    perDataIn = d; strobeN = 1'b0; tick(); strobeN = 1'b1; tick();
  endtask

  task automatic grant(logic [15:0] w);
    hostWordIn = w; dmaGrant = 1'b1; tick(); dmaGrant = 1'b0;
  endtask

  task automatic pulse_clear();
    clrFifo = 1'b1; tick(); clrFifo = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hang expected finish");
      finish_run();
    end
  end

  initial begin
    tick(); tick(); rstN = 1'b1; tick();
    // R1 reset state
    check("R1 dmaReq", 16'(dmaReq), 16'h0);
    check("R1 irqPullLow", 16'(irqPullLow), 16'h0);
    command(8'hEF);
    check("R1 status", 16'(perDataOut), 16'h00E0);

    // R2 idle command ignores strobes
    command(8'h55);
    check("R2 idle out", 16'(perDataOut), 16'h0000);
    strobe(8'h77);
    command(8'hF7);
    check("R2 fifo untouched", hostWordOut, 16'h0000);

    // R3 R4 R5 even block toward host
    for (int i = 0; i < 31; i++) strobe(8'(8'h10 + i));
    check("R5 below half", 16'(dmaReq), 16'h0);
    strobe(8'h2F);
    check("R5 at half", 16'(dmaReq), 16'h1);
    check("R4 packing", hostWordOut, 16'h1011);
    grant(16'h0);
    check("R5 drop after word", 16'(dmaReq), 16'h0);
    check("R4 next word", hostWordOut, 16'h1213);
    blockEnd = 1'b1; tick(); blockEnd = 1'b0;
    while (dmaReq) grant(16'h0);
    check("R5 flushed", hostWordOut, 16'h0000);

    // R6 odd block
    for (int i = 0; i < 5; i++) strobe(8'(8'hA0 + i));
    blockEnd = 1'b1; tick(); blockEnd = 1'b0;
    check("R6 word0", hostWordOut, 16'hA0A1);
    grant(16'h0);
    grant(16'h0);
    check("R6 padded", hostWordOut, 16'hA400);
    check("R6 still requesting", 16'(dmaReq), 16'h1);
    grant(16'h0);
    tick();
    check("R6 done", 16'(dmaReq), 16'h0);

    // R9 overflow, R10 clear
    for (int i = 0; i < 65; i++) strobe(8'(i));
    check("R9 req blocked", 16'(dmaReq), 16'h0);
    strobe(8'hEE);
    command(8'hEF);
    check("R9 status overflow", 16'(perDataOut), 16'h0080);
    pulse_clear();
    check("R10 status clear", 16'(perDataOut), 16'h00E0);
    check("R10 empty", hostWordOut, 16'h0000);

    // R7 R8 host fills, peripheral reads
    rdWrN = 1'b1;
    command(8'hF7);
    check("R8 request empty", 16'(dmaReq), 16'h1);
    for (int k = 0; k < 17; k++) grant({8'(2 * k), 8'(2 * k + 1)});
    check("R8 stop above half", 16'(dmaReq), 16'h0);
    for (int i = 0; i < 34; i++) begin
      strobe(8'h00);
      check("R7 read order", 16'(perDataOut), 16'(i));
    end
    strobe(8'h00);
    command(8'hEF);
    check("R9 status underflow", 16'(perDataOut), 16'h0080);
    pulse_clear();
    check("R10 status read dir", 16'(perDataOut), 16'h00A0);

    // R11 status strobes have no side effects
    command(8'hF7);
    grant(16'hBEEF);
    command(8'hEF);
    for (int i = 0; i < 3; i++) strobe(8'h00);
    check("R11 status", 16'(perDataOut), 16'h00E0);
    check("R11 fifo kept", hostWordOut, 16'hBEEF);
    command(8'hF7);
    strobe(8'h00);
    check("R11 byte after status", 16'(perDataOut), 16'h00BE);

    // R12 interrupt line
    irqAssert = 1'b1; tick(); irqAssert = 1'b0;
    check("R12 set", 16'(irqPullLow), 16'h1);
    command(8'h9F);
    check("R12 released", 16'(irqPullLow), 16'h0);
    check("R2 release mode idle", 16'(perDataOut), 16'h0000);
    irqAssert = 1'b1; cmdCode = 8'h9F; cmdLoad = 1'b1; tick();
    irqAssert = 1'b0; cmdLoad = 1'b0;
    check("R12 release wins", 16'(irqPullLow), 16'h0);

    tick();
    finish_run();
  end
endmodule